// File: doc/BRIEF.md
# Masked Conditional SIMD Array

This block is a small single-instruction, multiple-data array. One sequencer sends the same operation to every processing element on each step. Each element holds its own x, y and z words in private registers. The array evaluates `z = (y != 0) ? x / y : x` for all elements at once, using integer division, in three broadcast steps.

Branching is handled with a per-element activity flag rather than separate control paths. The first step sets the flag in every element from its own y. The second step runs the division only in flagged elements, and the unflagged ones sit idle. The third step copies x into z only in unflagged elements, and the flagged ones sit idle. Both branch arms therefore take time for the whole array.

The division is a sequential restoring divider in each element. The sequencer waits until every running divider has finished before it broadcasts the copy step. Software loads operands through a single write port and reads z and a per-element idle-cycle count back through an indexed read port.

Top module: `simd_cond_array`

## Requirements
- R1: After reset, `busy`, `done` and every bit of `flags` are 0, and every element reads back z = 0 and an idle count of 0.
- R2: While `busy` is 0, a cycle with `ldEn` high writes `ldX`, `ldY` and `ldZ` into the element selected by `ldIdx`. From the next cycle on, `rdZ` shows the written z when `rdIdx` selects that element.
- R3: The test step sets bit i of `flags` to 1 exactly when element i holds a nonzero y. `flags` changes only during a run.
- R4: In every element whose flag is set, the run leaves z equal to the unsigned integer quotient floor(x / y). This holds across the full 16-bit range, including x < y, x = 65535 and y = 65535.
- R5: In every element whose flag is clear, the run leaves z equal to x.
- R6: Idle elements do not write. While the dividers are running, every z still holds its value from before the run. The copy step is not broadcast while any divider is busy.
- R7: A start accepted at a rising edge drives `done` high for exactly one cycle after the 20th following rising edge if any y is nonzero. If every y is zero, this happens after the 4th following edge. `busy` is 0 from the cycle after `done`.
- R8: While `busy` is 1, `start` and `ldEn` have no effect. Loaded values stay unchanged, and no second run follows.
- R9: Each element's idle count is cleared when a run starts. It then counts the cycles from the test step through the copy step in which the element neither runs the broadcast step nor divides. The result is 2 for a flagged element. For an unflagged element it is 18, or 2 when no element is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a three-step run (sampled when not busy) |
| ldEn | input | 1 | Write strobe for element operands |
| ldIdx | input | 3 | Element selected for writing |
| ldX | input | 16 | x value to write |
| ldY | input | 16 | y value to write |
| ldZ | input | 16 | Initial z value to write |
| rdIdx | input | 3 | Element selected for reading |
| rdZ | output | 16 | z of the selected element |
| rdIdle | output | 8 | Idle-cycle count of the selected element |
| flags | output | 8 | Activity flag of each element |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The evaluation is tried with four y patterns: mixed zero and nonzero, all zero, all nonzero with boundary operands, and mixed with writes and starts injected during the run. The mixed pattern shows that flags pick the right arm per element, and that unflagged z stays untouched during the division. All-zero separates the short schedule from the long one and checks that no divider starts. The boundary pattern checks the divider at full range and with x < y. The injection case checks that a busy array ignores writes and new starts.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    OP_NOP    = 2'b00,
    OP_TEST   = 2'b01,
    OP_EXEC_T = 2'b10,
    OP_EXEC_F = 2'b11
  } op_t;

  typedef struct packed {
    op_t  op;
    logic issue;
    logic seqActive;
    logic clear;
  } stb_t;

endpackage

// File: rtl/simd_div.sv
module simd_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         doneP,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  remR, quoR, divR;
  logic [CW-1:0] cntR;
  logic          busyR, doneR;
  logic [W:0]    shifted, diff;
  logic [W-1:0]  nextRem;
  logic          qBit;

  always_comb begin
    shifted = {remR, quoR[W-1]};
    diff    = shifted - {1'b0, divR};
    if (diff[W]) begin
      nextRem = shifted[W-1:0];
      qBit    = 1'b0;
    end else begin
      nextRem = diff[W-1:0];
      qBit    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remR  <= '0;
      quoR  <= '0;
      divR  <= '0;
      cntR  <= '0;
      busyR <= 1'b0;
      doneR <= 1'b0;
    end else if (load) begin
      remR  <= '0;
      quoR  <= dividend;
      divR  <= divisor;
      cntR  <= '0;
      busyR <= 1'b1;
      doneR <= 1'b0;
    end else if (busyR) begin
      remR <= nextRem;
      quoR <= {quoR[W-2:0], qBit};
      cntR <= cntR + 1'b1;
      if (cntR == CW'(W - 1)) begin
        busyR <= 1'b0;
        doneR <= 1'b1;
      end
    end else begin
      doneR <= 1'b0;
    end
  end

  assign busy     = busyR;
  assign doneP    = doneR;
  assign quotient = quoR;
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  stb_t             stb,
  input  logic             ldEn,
  input  logic [W-1:0]     ldX,
  input  logic [W-1:0]     ldY,
  input  logic [W-1:0]     ldZ,
  output logic [W-1:0]     z,
  output logic             flag,
  output logic             busy,
  output logic [CNT_W-1:0] idleCnt
);
  logic [W-1:0]     xR, yR, zR;
  logic             flagR;
  logic [CNT_W-1:0] idleR;
  logic             exec, divLoad, divBusy, divDone;
  logic [W-1:0]     quo;

  always_comb begin
    exec = 1'b0;
    if (stb.issue) begin
      unique case (stb.op)
        OP_TEST:   exec = 1'b1;
        OP_EXEC_T: exec = flagR;
        OP_EXEC_F: exec = !flagR;
        default:   exec = 1'b0;
      endcase
    end
  end

  assign divLoad = exec && (stb.op == OP_EXEC_T);

  simd_div #(.W(W)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .load     (divLoad),
    .dividend (xR),
    .divisor  (yR),
    .busy     (divBusy),
    .doneP    (divDone),
    .quotient (quo)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xR    <= '0;
      yR    <= '0;
      zR    <= '0;
      flagR <= 1'b0;
    end else begin
      if (ldEn) begin
        xR <= ldX;
        yR <= ldY;
        zR <= ldZ;
      end
      if (exec && stb.op == OP_TEST) flagR <= (yR != '0);
      if (exec && stb.op == OP_EXEC_F) zR <= xR;
      if (divDone) zR <= quo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              idleR <= '0;
    else if (stb.clear)                     idleR <= '0;
    else if (stb.seqActive && !exec && !divBusy) idleR <= idleR + 1'b1;
  end

  assign z       = zR;
  assign flag    = flagR;
  assign busy    = divBusy;
  assign idleCnt = idleR;
endmodule

// File: rtl/simd_dp.sv
module simd_dp
  import simd_pkg::*;
#(
  parameter int NUM_PE = 8,
  parameter int W      = 16,
  parameter int CNT_W  = 8,
  parameter int IDX_W  = $clog2(NUM_PE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  stb_t              stb,
  input  logic              ldEn,
  input  logic [IDX_W-1:0]  ldIdx,
  input  logic [W-1:0]      ldX,
  input  logic [W-1:0]      ldY,
  input  logic [W-1:0]      ldZ,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [W-1:0]      rdZ,
  output logic [CNT_W-1:0]  rdIdle,
  output logic [NUM_PE-1:0] flags,
  output logic              anyBusy
);
  logic [W-1:0]     zArr    [NUM_PE];
  logic [CNT_W-1:0] idleArr [NUM_PE];
  logic [NUM_PE-1:0] busyVec;

  for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
    logic sel;
    assign sel = ldEn && (ldIdx == IDX_W'(i));
    simd_pe #(.W(W), .CNT_W(CNT_W)) u_pe (
      .clk     (clk),
      .rstN    (rstN),
      .stb     (stb),
      .ldEn    (sel),
      .ldX     (ldX),
      .ldY     (ldY),
      .ldZ     (ldZ),
      .z       (zArr[i]),
      .flag    (flags[i]),
      .busy    (busyVec[i]),
      .idleCnt (idleArr[i])
    );
  end

  assign anyBusy = |busyVec;
  assign rdZ     = zArr[rdIdx];
  assign rdIdle  = idleArr[rdIdx];
endmodule

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic anyBusy,
  output stb_t stb,
  output logic busy,
  output logic done
);
  typedef enum logic [2:0] {
    S_IDLE, S_TEST, S_EXT, S_WAIT, S_EXF, S_DONE
  } state_t;

  state_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:  if (start) nextState = S_TEST;
      S_TEST:  nextState = S_EXT;
      S_EXT:   nextState = S_WAIT;
      S_WAIT:  if (!anyBusy) nextState = S_EXF;
      S_EXF:   nextState = S_DONE;
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb.op        = OP_NOP;
    stb.issue     = 1'b0;
    stb.clear     = (state == S_IDLE) && start;
    stb.seqActive = (state == S_TEST) || (state == S_EXT) ||
                    (state == S_WAIT) || (state == S_EXF);
    unique case (state)
      S_TEST:  begin stb.op = OP_TEST;   stb.issue = 1'b1; end
      S_EXT:   begin stb.op = OP_EXEC_T; stb.issue = 1'b1; end
      S_EXF:   begin stb.op = OP_EXEC_F; stb.issue = 1'b1; end
      default: ;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
endmodule

// File: rtl/simd_cond_array.sv
module simd_cond_array
  import simd_pkg::*;
#(
  parameter int NUM_PE = 8,
  parameter int W      = 16,
  parameter int CNT_W  = 8,
  localparam int IDX_W = $clog2(NUM_PE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              ldEn,
  input  logic [IDX_W-1:0]  ldIdx,
  input  logic [W-1:0]      ldX,
  input  logic [W-1:0]      ldY,
  input  logic [W-1:0]      ldZ,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [W-1:0]      rdZ,
  output logic [CNT_W-1:0]  rdIdle,
  output logic [NUM_PE-1:0] flags,
  output logic              busy,
  output logic              done
);
  stb_t ctrlStb;
  logic anyBusy;
  logic ldGate;

  assign ldGate = ldEn && !busy;

  simd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .anyBusy (anyBusy),
    .stb     (ctrlStb),
    .busy    (busy),
    .done    (done)
  );

  simd_dp #(.NUM_PE(NUM_PE), .W(W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (ctrlStb),
    .ldEn    (ldGate),
    .ldIdx   (ldIdx),
    .ldX     (ldX),
    .ldY     (ldY),
    .ldZ     (ldZ),
    .rdIdx   (rdIdx),
    .rdZ     (rdZ),
    .rdIdle  (rdIdle),
    .flags   (flags),
    .anyBusy (anyBusy)
  );
endmodule

// File: rtl/simd_cond_array_chk.sv
module simd_cond_array_chk
  import simd_pkg::*;
#(
  parameter int NUM_PE = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic [NUM_PE-1:0] flags,
  input stb_t              stb,
  input logic              anyBusy
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy); // R7

  AST_FLAGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(flags)); // R3

  AST_COPY_AFTER_DIV: assert property (@(posedge clk) disable iff (!rstN)
    (stb.issue && stb.op == OP_EXEC_F) |-> !anyBusy); // R6

  AST_TEST_BEFORE_DIV: assert property (@(posedge clk) disable iff (!rstN)
    (stb.issue && stb.op == OP_EXEC_T) |-> $past(stb.issue && stb.op == OP_TEST)); // R3
endmodule

bind simd_cond_array simd_cond_array_chk #(.NUM_PE(NUM_PE)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .flags   (flags),
  .stb     (ctrlStb),
  .anyBusy (anyBusy)
);

// File: tb/simd_cond_array_bench.sv
module simd_cond_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SENT = 16'hA5A5;

  logic        clk = 1'b0;
  logic        rstN, start, ldEn;
  logic [2:0]  ldIdx, rdIdx;
  logic [15:0] ldX, ldY, ldZ, rdZ;
  logic [7:0]  rdIdle, flags;
  logic        busy, done;

  int testCnt = 0;
  int failCnt = 0;
  logic [15:0] xv [8];
  logic [15:0] yv [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_cond_array u_simd_cond_array (
    .clk(clk), .rstN(rstN), .start(start), .ldEn(ldEn), .ldIdx(ldIdx),
    .ldX(ldX), .ldY(ldY), .ldZ(ldZ), .rdIdx(rdIdx), .rdZ(rdZ),
    .rdIdle(rdIdle), .flags(flags), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic loadPe(input int idx, input logic [15:0] x, y, z);
    @(negedge clk);
    ldEn = 1'b1; ldIdx = 3'(idx); ldX = x; ldY = y; ldZ = z;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  task automatic peek(input int idx, output logic [15:0] z, output logic [7:0] idl);
    rdIdx = 3'(idx);
    #1;
    z = rdZ;
    idl = rdIdle;
  endtask

  task automatic t_reset();
    logic [15:0] z; logic [7:0] idl;
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 flags", int'(flags), 0);
    for (int i = 0; i < 8; i++) begin
      peek(i, z, idl);
      chk("R1 z", int'(z), 0);
      chk("R1 idle", int'(idl), 0);
    end
    loadPe(3, 16'd11, 16'd22, 16'h1234);
    peek(3, z, idl);
    chk("R2 load z readback", int'(z), 16'h1234);
  endtask

  task automatic runCase(input string name, input bit probe, input bit inject);
    logic [15:0] z; logic [7:0] idl;
    int cnt, expLat, expIdleOff;
    bit anyNz;
    logic [7:0] expFlags;
    anyNz = 1'b0;
    for (int i = 0; i < 8; i++) begin
      loadPe(i, xv[i], yv[i], SENT);
      expFlags[i] = (yv[i] != 0);
      if (yv[i] != 0) anyNz = 1'b1;
    end
    expLat     = anyNz ? 20 : 4;
    expIdleOff = anyNz ? 18 : 2;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 100) begin
      @(negedge clk);
      cnt++;
      if (inject && cnt == 3) begin
        start = 1'b1; ldEn = 1'b1; ldIdx = 3'd0;
        ldX = 16'h1111; ldY = 16'd1; ldZ = 16'h2222;
      end
      if (inject && cnt == 4) begin
        start = 1'b0; ldEn = 1'b0;
      end
      if (probe && cnt == 5) begin
        for (int i = 0; i < 8; i++) begin
          peek(i, z, idl);
          chk({"R6 z held during divide ", name}, int'(z), int'(SENT));
        end
      end
    end
    chk({"R7 latency ", name}, cnt, expLat);
    chk({"R3 flags ", name}, int'(flags), int'(expFlags));
    @(negedge clk);
    chk({"R7 busy low after done ", name}, int'(busy), 0);
    for (int i = 0; i < 8; i++) begin
      peek(i, z, idl);
      if (yv[i] != 0) begin
        chk({"R4 quotient ", name}, int'(z), int'(xv[i] / yv[i]));
        chk({"R9 idle flagged ", name}, int'(idl), 2);
      end else begin
        chk({"R5 copy ", name}, int'(z), int'(xv[i]));
        chk({"R9 idle unflagged ", name}, int'(idl), expIdleOff);
      end
    end
    if (inject) begin
      int seen = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (done || busy) seen++;
      end
      chk("R8 no second run", seen, 0);
    end
  endtask

  task automatic t_mixed();
    xv = '{16'd100, 16'd7, 16'd65535, 16'd5, 16'd1234, 16'd3, 16'd0, 16'd9};
    yv = '{16'd7, 16'd0, 16'd1, 16'd10, 16'd0, 16'd3, 16'd5, 16'd0};
    runCase("mixed", 1'b1, 1'b0);
  endtask

  task automatic t_allZero();
    xv = '{16'd1, 16'd2, 16'd300, 16'd4, 16'd65535, 16'd6, 16'd0, 16'd8};
    yv = '{16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0};
    runCase("allzero", 1'b0, 1'b0);
  endtask

  task automatic t_boundary();
    xv = '{16'd0, 16'd65535, 16'd65535, 16'd1, 16'd40000, 16'd12, 16'd65534, 16'd500};
    yv = '{16'd1, 16'd65535, 16'd1, 16'd2, 16'd3, 16'd12, 16'd65535, 16'd7};
    runCase("boundary", 1'b1, 1'b0);
  endtask

  task automatic t_busyIgnore();
    xv = '{16'd77, 16'd8, 16'd90, 16'd0, 16'd15, 16'd1000, 16'd2, 16'd33};
    yv = '{16'd5, 16'd0, 16'd9, 16'd4, 16'd0, 16'd999, 16'd0, 16'd2};
    runCase("busy-ignore", 1'b0, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; ldEn = 1'b0; ldIdx = '0; rdIdx = '0;
    ldX = '0; ldY = '0; ldZ = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mixed();
    t_allZero();
    t_boundary();
    t_busyIgnore();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule